// File: doc/BRIEF.md
# Bit-Serial Sum/Max Reduction Combiner

This block merges several bit-serial 32-bit words that arrive in lockstep on up to seven neighbour links into a single bit-serial result word bound for one destination link. A one-cycle start pulse marks the first bit of each word on every input line. Each of the following cycles carries one more bit. A per-link enable mask chooses which lines take part. A mode bit chooses between the wrapping integer sum and the unsigned maximum of the selected words.

The reduction runs bit by bit, with no buffering of the words. In sum mode the bits travel least significant first, and a small running carry links one bit position to the next. In max mode the bits travel most significant first. A candidate flag for each link drops a link as soon as it shows a 0 while some other remaining candidate shows a 1. Each result bit leaves one cycle after the input bits it depends on. The start pulse is forwarded with the same delay, so a chain of such blocks stays frame-aligned. When the last bit has gone out, the completed word is also presented in parallel.

Top module: `bitser_combiner`

## Requirements
- R1: While reset is asserted, and after its release until the first start pulse, `ser_out`, `frame_out` and `par_valid` are 0 and `par_out` is 0.
- R2: `frame_out` equals `frame_in` delayed by exactly one clock cycle.
- R3: Sum mode (`mode`=0) works least significant bit first. The input bit k of a word (k=0 in the `frame_in` cycle) produces result bit k on `ser_out` one cycle later, and the result is the sum of the selected words modulo 2^32.
- R4: Max mode (`mode`=1) works most significant bit first. The input bit k carries operand bit 31-k, and `ser_out` one cycle later carries bit 31-k of the unsigned maximum of the selected words.
- R5: A line whose `in_mask` bit is 0 has no effect. It adds nothing to the sum and can never be the maximum.
- R6: An all-zero mask yields the result 0 in both modes.
- R7: `mode` and `in_mask` are taken only in the `frame_in` cycle. Changing them later in the word has no effect on that word's result.
- R8: When the 32nd output bit is on `ser_out`, `par_valid` is high for that single cycle and `par_out` holds the whole result word in its natural bit order. `par_out` keeps that value until the next word completes.
- R9: A `frame_in` pulse arriving in the middle of a word restarts the reduction. No carry and no candidate state from the abandoned word reaches the new one.
- R10: Outside a word (after bit 31 and before the next start), `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_in | input | 1 | Start pulse, high in the cycle carrying bit 0 of all input words |
| ser_in | input | 7 | One serial data line per neighbour link |
| in_mask | input | 7 | Per-link participation enable, taken at start |
| mode | input | 1 | 0 = wrapping sum, 1 = unsigned maximum, taken at start |
| ser_out | output | 1 | Serial result bit |
| frame_out | output | 1 | Start pulse aligned with result bit 0 |
| par_out | output | 32 | Last completed result word |
| par_valid | output | 1 | One-cycle pulse when `par_out` is updated |

## Verification
The hardest situations to reach from the ports are state leaking across a word boundary and late changes to the configuration. A carry left over from a wrapping sum, or a stale candidate set in max mode, shows up only when a new start pulse cuts into a word that is still running. The stimulus therefore drives partial words of all-ones, or of a single dominant line, and then restarts them with a fresh word whose expected result differs from any leaked value. The sweeps run every mask value in both modes, with wraparound operands and ties. In some words `mode` and `in_mask` are toggled right after the start cycle, so that a design which samples them late gives a different word.

// File: rtl/bitser_combiner_pkg.sv
package bitser_combiner_pkg;
  typedef enum logic {
    OP_SUM = 1'b0,
    OP_MAX = 1'b1
  } op_e;
endpackage

// File: rtl/cmb_sum_slice.sv
// Serial adder across N_LINKS lines with a multi-bit running carry.
module cmb_sum_slice #(
  parameter int N_LINKS = 7,
  localparam int CW = $clog2(N_LINKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start,
  input  logic [N_LINKS-1:0] bits_i,
  output logic               bit_o
);
  logic [CW-1:0] carry_q, carry_d;
  logic [CW:0]   total;

  always_comb begin
    total = (start ? '0 : {1'b0, carry_q});
    for (int i = 0; i < N_LINKS; i++) begin
      total = total + {{CW{1'b0}}, bits_i[i]};
    end
    bit_o   = total[0];
    carry_d = total[CW:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= '0;
    end else if (en) begin
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/cmb_max_slice.sv
// Serial unsigned maximum: MSB first, candidate elimination per link.
module cmb_max_slice #(
  parameter int N_LINKS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start,
  input  logic [N_LINKS-1:0] bits_i,
  input  logic [N_LINKS-1:0] mask_i,
  output logic               bit_o
);
  logic [N_LINKS-1:0] cand_q, cand_d, cand_cur, ones;

  always_comb begin
    cand_cur = start ? mask_i : cand_q;
    ones     = bits_i & cand_cur;
    bit_o    = |ones;
    cand_d   = bit_o ? ones : cand_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
    end else if (en) begin
      cand_q <= cand_d;
    end
  end
endmodule

// File: rtl/cmb_word_tracker.sv
// Bit position counter and result deserializer.
module cmb_word_tracker
  import bitser_combiner_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int IW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               op,
  input  logic              bit_i,
  output logic              live_o,
  output logic [WORD_W-1:0] par_o,
  output logic              par_valid_o
);
  logic              active_q, active_d;
  logic [IW-1:0]     cnt_q, cnt_d, idx_cur;
  logic [WORD_W-1:0] acc_q, acc_d, par_q, par_d;
  logic              last, valid_q;

  always_comb begin
    idx_cur  = start ? '0 : cnt_q;
    live_o   = start | active_q;
    last     = live_o && (idx_cur == IW'(WORD_W - 1));
    active_d = live_o && !last;
    cnt_d    = live_o ? idx_cur + 1'b1 : cnt_q;
    acc_d    = acc_q;
    if (live_o) begin
      if (op == OP_SUM) acc_d = {bit_i, acc_q[WORD_W-1:1]};
      else              acc_d = {acc_q[WORD_W-2:0], bit_i};
    end
    par_d = last ? acc_d : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      par_q    <= '0;
      valid_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      valid_q  <= last;
      if (live_o) begin
        cnt_q <= cnt_d;
        acc_q <= acc_d;
      end
      if (last) begin
        par_q <= par_d;
      end
    end
  end

  assign par_o       = par_q;
  assign par_valid_o = valid_q;
endmodule

// File: rtl/bitser_combiner.sv
module bitser_combiner
  import bitser_combiner_pkg::*;
#(
  parameter int N_LINKS = 7,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_in,
  input  logic [N_LINKS-1:0] ser_in,
  input  logic [N_LINKS-1:0] in_mask,
  input  logic               mode,
  output logic               ser_out,
  output logic               frame_out,
  output logic [WORD_W-1:0]  par_out,
  output logic               par_valid
);
  op_e                mode_q;
  logic [N_LINKS-1:0] mask_q;
  op_e                eff_mode;
  logic [N_LINKS-1:0] eff_mask;
  logic               live;
  logic               sum_bit, max_bit, res_bit;
  logic               ser_d;
  logic               ser_q, frame_q;

  always_comb begin
    eff_mode = frame_in ? op_e'(mode) : mode_q;
    eff_mask = frame_in ? in_mask : mask_q;
    res_bit  = (eff_mode == OP_SUM) ? sum_bit : max_bit;
    ser_d    = live & res_bit;
  end

  cmb_sum_slice #(.N_LINKS(N_LINKS)) u_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (live),
    .start  (frame_in),
    .bits_i (ser_in & eff_mask),
    .bit_o  (sum_bit)
  );

  cmb_max_slice #(.N_LINKS(N_LINKS)) u_max (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (live),
    .start  (frame_in),
    .bits_i (ser_in),
    .mask_i (eff_mask),
    .bit_o  (max_bit)
  );

  cmb_word_tracker #(.WORD_W(WORD_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (frame_in),
    .op          (eff_mode),
    .bit_i       (res_bit),
    .live_o      (live),
    .par_o       (par_out),
    .par_valid_o (par_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= OP_SUM;
      mask_q  <= '0;
      ser_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      ser_q   <= ser_d;
      frame_q <= frame_in;
      if (frame_in) begin
        mode_q <= op_e'(mode);
        mask_q <= in_mask;
      end
    end
  end

  assign ser_out   = ser_q;
  assign frame_out = frame_q;
endmodule

// File: rtl/bitser_combiner_chk.sv
module bitser_combiner_chk
  import bitser_combiner_pkg::*;
#(
  parameter int N_LINKS = 7,
  parameter int WORD_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_in,
  input logic [N_LINKS-1:0] ser_in,
  input logic [N_LINKS-1:0] in_mask,
  input logic               ser_out,
  input logic               frame_out,
  input logic [WORD_W-1:0]  par_out,
  input logic               par_valid,
  input op_e                eff_mode,
  input logic [N_LINKS-1:0] eff_mask
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: outputs cleared while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!ser_out && !frame_out && !par_valid && par_out == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_frame_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (frame_out == $past(frame_in)));

  p_max_needs_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == OP_MAX && (ser_in & eff_mask) == '0) |=> !ser_out);

  p_empty_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_in && in_mask == '0) |=> !ser_out);

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    par_valid |=> !par_valid);

  p_par_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !par_valid) |-> $stable(par_out));
endmodule

bind bitser_combiner bitser_combiner_chk #(.N_LINKS(N_LINKS), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_in  (frame_in),
  .ser_in    (ser_in),
  .in_mask   (in_mask),
  .ser_out   (ser_out),
  .frame_out (frame_out),
  .par_out   (par_out),
  .par_valid (par_valid),
  .eff_mode  (eff_mode),
  .eff_mask  (eff_mask)
);

// File: tb/bitser_combiner_test.sv
module bitser_combiner_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 7;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         frame_in;
  logic [N-1:0] ser_in;
  logic [N-1:0] in_mask;
  logic         mode;
  logic         ser_out, frame_out, par_valid;
  logic [W-1:0] par_out;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [W-1:0] vals [N];

  bitser_combiner #(.N_LINKS(N), .WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .ser_in(ser_in),
    .in_mask(in_mask), .mode(mode), .ser_out(ser_out), .frame_out(frame_out),
    .par_out(par_out), .par_valid(par_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [W-1:0] expect_word(input logic [N-1:0] m, input bit op);
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        if (!op) r = r + vals[i];
        else if (vals[i] > r) r = vals[i];
      end
    end
    return r;
  endfunction

  // Drive one full word; optionally disturb mask/mode after the start cycle (R7).
  task automatic run_word(input logic [N-1:0] m, input bit op, input bit disturb,
                          input string req);
    logic [W-1:0] exp, got;
    bit fr_ok = 1'b1;
    bit gap_ok = 1'b1;
    exp = expect_word(m, op);
    got = '0;
    for (int k = 0; k <= W; k++) begin
      @(negedge clk);
      if (k > 0) begin
        if (!op) got[k-1] = ser_out; else got[W-k] = ser_out;
        if (frame_out !== (k == 1)) fr_ok = 1'b0;
        if (k < W && par_valid !== 1'b0) fr_ok = 1'b0;
      end
      if (k < W) begin
        frame_in = (k == 0);
        for (int i = 0; i < N; i++) ser_in[i] = op ? vals[i][W-1-k] : vals[i][k];
        if (k == 0) begin
          in_mask = m; mode = op;
        end else if (disturb) begin
          in_mask = ~m; mode = ~op;
        end
      end else begin
        frame_in = 1'b0; ser_in = '1;
      end
    end
    check(got === exp, req, got, exp);
    check(par_valid === 1'b1 && par_out === exp, "R8 par_out/par_valid", par_out, exp);
    check(fr_ok, "R2 frame_out delay", {31'd0, fr_ok}, 32'd1);
    @(negedge clk);
    if (ser_out !== 1'b0 || par_valid !== 1'b0 || par_out !== exp) gap_ok = 1'b0;
    check(gap_ok, "R10 idle ser_out low / R8 hold", {31'd0, ser_out}, 32'd0);
    ser_in = '0;
  endtask

  // Start a word and abandon it after nbits (for R9).
  task automatic partial_word(input logic [N-1:0] m, input bit op, input int nbits,
                              input logic [W-1:0] pat);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      frame_in = (k == 0);
      in_mask = m; mode = op;
      ser_in = pat[k] ? '1 : '0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests_run++; tests_failed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_in = 1'b0; ser_in = '0; in_mask = '0; mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ser_out === 0 && frame_out === 0 && par_valid === 0 && par_out === '0,
          "R1 reset outputs", par_out, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ser_out === 0 && frame_out === 0 && par_valid === 0 && par_out === '0,
          "R1 idle after release", par_out, '0);

    // R3/R4/R5/R6: every mask in both modes with pseudo-random operands
    for (int op = 0; op < 2; op++) begin
      for (int m = 0; m < (1 << N); m++) begin
        for (int i = 0; i < N; i++) vals[i] = rnd();
        if (m == 0) run_word(N'(m), op[0], 1'b0, "R6 empty mask gives 0");
        else if (op == 0) run_word(N'(m), 1'b0, 1'b0, "R3 R5 masked sum");
        else run_word(N'(m), 1'b1, 1'b0, "R4 R5 masked max");
      end
    end

    // R3 wraparound: seven all-ones words sum to -7 mod 2^32
    for (int i = 0; i < N; i++) vals[i] = '1;
    run_word('1, 1'b0, 1'b0, "R3 wrap modulo 2^32");
    // R4 ties and LSB-only differences
    for (int i = 0; i < N; i++) vals[i] = 32'hFFFF_FFF0 | W'(i);
    run_word('1, 1'b1, 1'b0, "R4 max differing in low bits");
    for (int i = 0; i < N; i++) vals[i] = 32'h8000_0000;
    run_word(7'h55, 1'b1, 1'b0, "R4 max with ties");
    // R5: masked-off line holds the largest value
    for (int i = 0; i < N; i++) vals[i] = W'(i + 1);
    vals[6] = 32'hFFFF_FFFF;
    run_word(7'h3F, 1'b1, 1'b0, "R5 masked max ignored");
    run_word(7'h3F, 1'b0, 1'b0, "R5 masked sum ignored");

    // R7: mask and mode flipped after start must not matter
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < N; i++) vals[i] = rnd();
      run_word(N'(rnd()), r[0], 1'b1, "R7 late mask/mode change ignored");
    end

    // R9: restart mid-word, sum mode with a large pending carry
    partial_word('1, 1'b0, 10, '1);
    for (int i = 0; i < N; i++) vals[i] = W'(i);
    run_word('1, 1'b0, 1'b0, "R9 restart clears carry");
    // R9: restart mid-word, max mode with a narrowed candidate set
    partial_word(7'h01, 1'b1, 12, '1);
    for (int i = 0; i < N; i++) vals[i] = W'(i * 100);
    run_word('1, 1'b1, 1'b0, "R9 restart clears candidates");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule